// File: doc/BRIEF.md
# Ping-Pong DMA Receive Channel

This block is one DMA channel that drains a peripheral's receive data register into memory. It holds two descriptors, primary and alternate. Each descriptor carries a destination pointer, a count of items still to move, and a run/stop mode. The primary descriptor fills buffer A and the alternate fills buffer B. When one buffer is full, the channel moves straight on to the other one, raises a one-cycle completion interrupt, and leaves the finished descriptor stopped so that software can reload it.

The peripheral asks for service on two lines. A single request means one item is ready. A burst request means a FIFO threshold has been reached. A burst moves the programmed arbitration size, cut down to the items left in the buffer. A single request moves one item. A burst-only control makes the channel ignore single requests. When both lines are high, the burst request wins.

The channel moves one item per clock. At the end of each service it pulses an acknowledge to the peripheral and records how many items that service moved. If the channel hands over to a descriptor that is still stopped, it flags an underrun and accepts no requests until that descriptor is reloaded.

Top module: `pp_rx_dma`

## Requirements
- R1: After a synchronous active-low reset, both descriptors are stopped with count 0, the primary descriptor is active, and every flag, `last_cnt` and every strobe output are 0.
- R2: With `use_burst`=0 and only `req_single` high, an idle channel whose active descriptor is running moves exactly one item.
- R3: A burst request moves min(A, remaining) items, where A is `arb_size` and an `arb_size` of 0 counts as 1.
- R4: When `req_single` and `req_burst` are both high, the service is sized as a burst.
- R5: With `use_burst`=1, a single request alone moves nothing and leaves the descriptor counts unchanged.
- R6: Each moved item asserts `mem_we` for one cycle, writes `periph_data` to `mem_addr`, and `mem_addr` starts at the loaded base and rises by 1 per item, wrapping modulo 2^ADDR_W.
- R7: A descriptor's count falls by 1 per item. When it reaches 0, that descriptor's run bit clears.
- R8: On the cycle that moves a buffer's last item, `irq` is high for that cycle only, and `active_alt` toggles on the next edge, so the next request is served from the other buffer.
- R9: `done_prim` / `done_alt` set when the primary / alternate buffer completes and stay set until a clear write with `clr_mask` bit 0 / bit 1. A new completion in the same cycle wins over the clear.
- R10: If a buffer completes while the other descriptor is stopped and is not being loaded that cycle, `err` sets (sticky, cleared by `clr_mask` bit 2) and no item moves until the active descriptor is loaded.
- R11: `last_cnt` holds the number of items moved by the most recent service. It is cleared by `clr_mask` bit 3, and a new value in the same cycle wins over the clear.
- R12: `xfer_ack` is high exactly on the cycle that moves the final item of a service.
- R13: A load (`ld_en`, with `ld_alt` choosing the alternate descriptor) sets that descriptor's pointer and count. It runs if the count is nonzero and stays stopped if the count is 0. A load takes priority over an item step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_single | input | 1 | Peripheral has one item ready |
| req_burst | input | 1 | Peripheral has a burst ready |
| periph_data | input | DATA_W | Peripheral receive data register |
| use_burst | input | 1 | Ignore single requests |
| arb_size | input | CNT_W | Items per burst (0 treated as 1) |
| ld_en | input | 1 | Descriptor load strobe |
| ld_alt | input | 1 | Load target: 0 primary, 1 alternate |
| ld_base | input | ADDR_W | Destination base for the load |
| ld_count | input | CNT_W | Item count for the load |
| clr_en | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | 4 | Clear bits: 0 done_prim, 1 done_alt, 2 err, 3 last_cnt |
| mem_we | output | 1 | Memory write strobe, one item |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| xfer_ack | output | 1 | Final item of a service |
| irq | output | 1 | Buffer completion pulse |
| active_alt | output | 1 | Alternate descriptor active |
| prim_run | output | 1 | Primary descriptor running |
| prim_count | output | CNT_W | Primary items outstanding |
| alt_run | output | 1 | Alternate descriptor running |
| alt_count | output | CNT_W | Alternate items outstanding |
| done_prim | output | 1 | Sticky primary completion |
| done_alt | output | 1 | Sticky alternate completion |
| err | output | 1 | Sticky underrun |
| last_cnt | output | CNT_W | Items moved by the last service |

## Verification
The bench builds the block with ADDR_W=12, CNT_W=6 and DATA_W=8, and loads buffers of at most 12 items. Arbitration sizes of 0 to 7 against such short buffers make the burst cap, the zero-size rule and a burst that ends exactly on a buffer boundary all common events. Random reloads, clears and mixed request levels drive both buffer hand-overs and underruns, with stopped descriptors reloaded at random times. The pointer wrap at 2^12 is left to the in-module address assertion.

// File: rtl/pp_rx_dma_pkg.sv
// Shared types for the ping-pong receive channel.
package pp_rx_dma_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MOVE = 1'b1
    } chan_st_e;
endpackage

// File: rtl/pp_rx_desc.sv
// One transfer descriptor: destination pointer, outstanding count and run bit.
// Assumes step is only raised while the descriptor runs; a load overrides a step.
module pp_rx_desc #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              run_o
);
    // Descriptor update: load, or advance by one item.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            count_o <= '0;
            run_o   <= 1'b0;
        end else if (ld) begin
            addr_o  <= ld_base;
            count_o <= ld_count;
            run_o   <= (ld_count != '0);
        end else if (step) begin
            addr_o  <= addr_o + 1'b1;
            count_o <= count_o - 1'b1;
            if (count_o == CNT_W'(1)) run_o <= 1'b0;
        end
    end

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld) |=> addr_o == $past(addr_o) + 1'b1);
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && count_o > CNT_W'(1)) |=> count_o == $past(count_o) - 1'b1);
    assert_stop_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && count_o == CNT_W'(1)) |=> (!run_o && count_o == '0));
endmodule

// File: rtl/pp_rx_arb.sv
// Request decision: burst first, single suppressed in burst-only mode,
// burst length capped at the items remaining. Pure combinational.
module pp_rx_arb #(
    parameter int CNT_W = 6
) (
    input  logic             ready,
    input  logic             req_single,
    input  logic             req_burst,
    input  logic             use_burst,
    input  logic [CNT_W-1:0] arb_size,
    input  logic [CNT_W-1:0] remain,
    output logic             grant,
    output logic             grant_burst,
    output logic [CNT_W-1:0] grant_len
);
    logic [CNT_W-1:0] arb_eff;
    logic [CNT_W-1:0] burst_len;

    // Choose the request served and its length.
    always_comb begin
        arb_eff     = (arb_size == '0) ? CNT_W'(1) : arb_size;
        burst_len   = (arb_eff < remain) ? arb_eff : remain;
        grant_burst = ready && req_burst;
        grant       = grant_burst || (ready && req_single && !use_burst);
        grant_len   = grant_burst ? burst_len : CNT_W'(1);
    end
endmodule

// File: rtl/pp_rx_dma.sv
// Ping-pong receive DMA channel top. Moves one item per cycle from the
// peripheral data register to memory, alternating between two descriptors.
// Assumes software does not reload the active descriptor mid-service.
module pp_rx_dma
    import pp_rx_dma_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_single,
    input  logic              req_burst,
    input  logic [DATA_W-1:0] periph_data,
    input  logic              use_burst,
    input  logic [CNT_W-1:0]  arb_size,
    input  logic              ld_en,
    input  logic              ld_alt,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic              clr_en,
    input  logic [3:0]        clr_mask,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              xfer_ack,
    output logic              irq,
    output logic              active_alt,
    output logic              prim_run,
    output logic [CNT_W-1:0]  prim_count,
    output logic              alt_run,
    output logic [CNT_W-1:0]  alt_count,
    output logic              done_prim,
    output logic              done_alt,
    output logic              err,
    output logic [CNT_W-1:0]  last_cnt
);
    localparam int NDESC = 2;

    chan_st_e          state;
    logic [CNT_W-1:0]  left;
    logic [CNT_W-1:0]  svc_len;
    logic              act;
    logic              moving;
    logic              last_item;
    logic              buf_end;
    logic              other_ready;
    logic              grant;
    logic              grant_burst;
    logic [CNT_W-1:0]  grant_len;
    logic [ADDR_W-1:0] d_addr  [NDESC];
    logic [CNT_W-1:0]  d_count [NDESC];
    logic              d_run   [NDESC];
    logic              d_ld    [NDESC];
    logic              d_step  [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_desc
        assign d_ld[g]   = ld_en && (ld_alt == 1'(g));
        assign d_step[g] = moving && (act == 1'(g));
        pp_rx_desc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld      (d_ld[g]),
            .ld_base (ld_base),
            .ld_count(ld_count),
            .step    (d_step[g]),
            .addr_o  (d_addr[g]),
            .count_o (d_count[g]),
            .run_o   (d_run[g])
        );
    end

    pp_rx_arb #(.CNT_W(CNT_W)) u_arb (
        .ready      ((state == ST_IDLE) && d_run[act]),
        .req_single (req_single),
        .req_burst  (req_burst),
        .use_burst  (use_burst),
        .arb_size   (arb_size),
        .remain     (d_count[act]),
        .grant      (grant),
        .grant_burst(grant_burst),
        .grant_len  (grant_len)
    );

    // Per-cycle strobes derived from channel state.
    always_comb begin
        moving      = (state == ST_MOVE);
        last_item   = moving && (left == CNT_W'(1));
        buf_end     = moving && (d_count[act] == CNT_W'(1));
        other_ready = d_run[~act] || (d_ld[~act] && ld_count != '0);
    end

    // Service sequencing and descriptor hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            left    <= '0;
            svc_len <= '0;
            act     <= 1'b0;
        end else if (moving) begin
            left <= left - 1'b1;
            if (last_item || buf_end) state <= ST_IDLE;
            if (buf_end) act <= ~act;
        end else if (grant) begin
            state   <= ST_MOVE;
            left    <= grant_len;
            svc_len <= grant_len;
        end
    end

    // Sticky flags and last-service count, write-1-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_prim <= 1'b0;
            done_alt  <= 1'b0;
            err       <= 1'b0;
            last_cnt  <= '0;
        end else begin
            done_prim <= (done_prim && !(clr_en && clr_mask[0])) || (buf_end && !act);
            done_alt  <= (done_alt  && !(clr_en && clr_mask[1])) || (buf_end && act);
            err       <= (err && !(clr_en && clr_mask[2])) || (buf_end && !other_ready);
            if (last_item || buf_end) last_cnt <= svc_len - left + 1'b1;
            else if (clr_en && clr_mask[3]) last_cnt <= '0;
        end
    end

    assign mem_we     = moving;
    assign mem_addr   = d_addr[act];
    assign mem_wdata  = periph_data;
    assign xfer_ack   = last_item || buf_end;
    assign irq        = buf_end;
    assign active_alt = act;
    assign prim_run   = d_run[0];
    assign prim_count = d_count[0];
    assign alt_run    = d_run[1];
    assign alt_count  = d_count[1];

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> active_alt != $past(active_alt));
    assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (grant_len != '0 && grant_len <= d_count[act]));
    assert_burst_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_burst) |-> grant_burst);
    assert_burst_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && use_burst) |-> grant_burst);
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !d_run[act]) |=> !mem_we);
endmodule

// File: tb/tb_pp_rx_dma.sv
// Bench: behavioural reference model stepped on each edge, compared every cycle.
module tb_pp_rx_dma;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 6;
    localparam int DATA_W = 8;
    localparam int AMASK  = (1 << ADDR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_single = 1'b0, req_burst = 1'b0;
    logic [DATA_W-1:0] periph_data = '0;
    logic use_burst = 1'b0;
    logic [CNT_W-1:0] arb_size = '0;
    logic ld_en = 1'b0, ld_alt = 1'b0;
    logic [ADDR_W-1:0] ld_base = '0;
    logic [CNT_W-1:0] ld_count = '0;
    logic clr_en = 1'b0;
    logic [3:0] clr_mask = '0;
    logic mem_we, xfer_ack, irq, active_alt, prim_run, alt_run;
    logic done_prim, done_alt, err;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [CNT_W-1:0] prim_count, alt_count, last_cnt;

    pp_rx_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_single(req_single), .req_burst(req_burst),
        .periph_data(periph_data), .use_burst(use_burst), .arb_size(arb_size),
        .ld_en(ld_en), .ld_alt(ld_alt), .ld_base(ld_base), .ld_count(ld_count),
        .clr_en(clr_en), .clr_mask(clr_mask), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .xfer_ack(xfer_ack), .irq(irq), .active_alt(active_alt),
        .prim_run(prim_run), .prim_count(prim_count), .alt_run(alt_run),
        .alt_count(alt_count), .done_prim(done_prim), .done_alt(done_alt),
        .err(err), .last_cnt(last_cnt)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit we_seen = 1'b0;

    // Reference state.
    int m_state, m_left, m_len, m_act, m_err, m_last;
    int m_cnt [2];
    int m_addr[2];
    int m_run [2];
    int m_done[2];

    task automatic chk(input string tag, input int act_v, input int exp_v);
        vectors++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act_v, exp_v);
        end
    endtask

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_len = 0; m_act = 0; m_err = 0; m_last = 0;
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_addr[i] = 0; m_run[i] = 0; m_done[i] = 0;
            end
        end else begin
            int c, oth, gl, a;
            bit mv, lastit, bend, oth_ready;
            c = m_cnt[m_act];
            oth = 1 - m_act;
            mv = (m_state == 1);
            lastit = mv && m_left == 1;
            bend = mv && c == 1;
            oth_ready = (m_run[oth] != 0) || (ld_en && int'(ld_alt) == oth && ld_count != 0);
            gl = 0;
            if (!mv && m_run[m_act] != 0) begin
                if (req_burst) begin
                    a = (arb_size == 0) ? 1 : int'(arb_size);
                    gl = (a < c) ? a : c;
                end else if (req_single && !use_burst) gl = 1;
            end
            if (clr_en) begin
                if (clr_mask[0]) m_done[0] = 0;
                if (clr_mask[1]) m_done[1] = 0;
                if (clr_mask[2]) m_err = 0;
                if (clr_mask[3]) m_last = 0;
            end
            if (lastit || bend) m_last = m_len - m_left + 1;
            if (bend) begin
                m_done[m_act] = 1;
                if (!oth_ready) m_err = 1;
            end
            if (mv) begin
                m_addr[m_act] = (m_addr[m_act] + 1) & AMASK;
                m_cnt[m_act] = c - 1;
                if (c == 1) m_run[m_act] = 0;
            end
            if (ld_en) begin
                m_addr[ld_alt] = int'(ld_base);
                m_cnt[ld_alt] = int'(ld_count);
                m_run[ld_alt] = (ld_count != 0) ? 1 : 0;
            end
            if (mv) begin
                m_left = m_left - 1;
                if (lastit || bend) m_state = 0;
                if (bend) m_act = oth;
            end else if (gl > 0) begin
                m_state = 1; m_left = gl; m_len = gl;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (mem_we) we_seen = 1'b1;
        chk("R6 mem_we", int'(mem_we), m_state);
        if (m_state == 1) begin
            chk("R6 mem_addr", int'(mem_addr), m_addr[m_act]);
            chk("R6 mem_wdata", int'(mem_wdata), int'(periph_data));
        end
        chk("R12 xfer_ack", int'(xfer_ack),
            (m_state == 1 && (m_left == 1 || m_cnt[m_act] == 1)) ? 1 : 0);
        chk("R8 irq", int'(irq), (m_state == 1 && m_cnt[m_act] == 1) ? 1 : 0);
        chk("R8 active_alt", int'(active_alt), m_act);
        chk("R7 prim_count", int'(prim_count), m_cnt[0]);
        chk("R7 alt_count", int'(alt_count), m_cnt[1]);
        chk("R13 prim_run", int'(prim_run), m_run[0]);
        chk("R13 alt_run", int'(alt_run), m_run[1]);
        chk("R9 done_prim", int'(done_prim), m_done[0]);
        chk("R9 done_alt", int'(done_alt), m_done[1]);
        chk("R10 err", int'(err), m_err);
        chk("R11 last_cnt", int'(last_cnt), m_last);
        periph_data <= periph_data + 8'd37;
    end

    task automatic load(input bit alt, input int base, input int cnt);
        @(negedge clk);
        ld_en = 1'b1; ld_alt = alt; ld_base = ADDR_W'(base); ld_count = CNT_W'(cnt);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic request(input bit s, input bit b, input int max_wait);
        @(negedge clk);
        req_single = s; req_burst = b;
        for (int i = 0; i < max_wait; i++) begin
            @(negedge clk);
            if (xfer_ack) break;
        end
        req_single = 1'b0; req_burst = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk);
        clr_en = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 prim_count", int'(prim_count), 0);
        chk("R1 run bits", int'({prim_run, alt_run}), 0);
        chk("R1 flags", int'({done_prim, done_alt, err, irq, mem_we, xfer_ack}), 0);
        chk("R1 active_alt", int'(active_alt), 0);
        rst_n = 1'b1;
        arb_size = 6'd4;
        load(1'b0, 'h100, 10);
        load(1'b1, 'h200, 6);
        request(1'b1, 1'b0, 10);
        chk("R2 single len", int'(last_cnt), 1);
        request(1'b0, 1'b1, 10);
        chk("R3 burst len", int'(last_cnt), 4);
        request(1'b0, 1'b1, 10);
        request(1'b0, 1'b1, 10);
        chk("R3 capped burst", int'(last_cnt), 1);
        chk("R8 switched", int'(active_alt), 1);
        chk("R9 done_prim set", int'(done_prim), 1);
        request(1'b1, 1'b1, 10);
        chk("R4 burst wins", int'(last_cnt), 4);
        use_burst = 1'b1;
        we_seen = 1'b0;
        @(negedge clk); req_single = 1'b1;
        repeat (6) @(negedge clk);
        req_single = 1'b0;
        chk("R5 single ignored", int'(we_seen), 0);
        chk("R5 count held", int'(alt_count), 2);
        use_burst = 1'b0;
        request(1'b1, 1'b0, 10);
        request(1'b1, 1'b0, 10);
        chk("R10 err on stopped", int'(err), 1);
        we_seen = 1'b0;
        @(negedge clk); req_burst = 1'b1;
        repeat (6) @(negedge clk);
        req_burst = 1'b0;
        chk("R10 halted", int'(we_seen), 0);
        load(1'b0, 'h300, 0);
        chk("R13 zero load stops", int'(prim_run), 0);
        load(1'b0, 'h300, 3);
        arb_size = 6'd0;
        request(1'b0, 1'b1, 10);
        chk("R3 zero arb", int'(last_cnt), 1);
        clear(4'hF);
        chk("R9 cleared", int'({done_prim, done_alt}), 0);
        chk("R11 cleared", int'(last_cnt), 0);
        // Mixed random traffic against the model.
        for (int it = 0; it < 400; it++) begin
            if (!prim_run && $urandom_range(1, 0) == 1) load(1'b0, $urandom_range(4095, 0), $urandom_range(12, 0));
            if (!alt_run && $urandom_range(1, 0) == 1) load(1'b1, $urandom_range(4095, 0), $urandom_range(12, 0));
            arb_size = CNT_W'($urandom_range(7, 0));
            use_burst = ($urandom_range(3, 0) == 0);
            if ($urandom_range(7, 0) == 0) clear(4'($urandom_range(15, 0)));
            request(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), 6);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule